// File: doc/BRIEF.md
# Non-Faulting Translation Probe and Load Unit

This block is a small address translation front end placed ahead of a data memory. It keeps a fully associative translation cache keyed by virtual page number. It serves one request at a time, and each request is one of three kinds. A cache-only probe asks whether a page is currently cached. A walking probe also reads the page table when the cache misses. A try-load translates the address and reads a data word.

No request ever raises a fault. Every outcome comes back as a carry-style status bit next to a result word. A successful try-load also carries zero, sign and parity flags derived from the loaded word.

The page table has a single level and is indexed directly by virtual page number. It is read through a one-cycle-latency memory port. A second port of the same kind reads data words at the translated physical address. A per-request no-walk bit lets software use a try-load purely as a cheap test: any cache miss then counts as an abort.

Top module: `xlat_probe_unit`

## Requirements
- R1: A cache-only probe (kind 0, and also kind 3) never asserts `pte_rd_en`. It returns status 1 when the page is cached and status 0 otherwise, with result 0.
- R2: A walking probe (kind 1) returns status 1 on a cache hit. On a miss it reads the page-table entry at the virtual page number and returns that entry's present bit as status. Its result is 0.
- R3: When a try-load (kind 2) finds a valid mapping, it reads the data memory at {physical page, original page offset}. It returns status 1 with the word read.
- R4: When a try-load finds no valid mapping, it returns status 0, result 0 and all flags 0, and it raises no fault.
- R5: On a successful try-load, `rsp_zf` is 1 if the word is zero, `rsp_sf` equals the word's top bit, and `rsp_pf` is 1 if the word has an even number of one bits. For every other response all three flags are 0.
- R6: A try-load with `req_nowalk`=1 that misses the cache returns status 0 without reading the page table. With `req_nowalk`=0 it walks. Probes ignore `req_nowalk`.
- R7: A walk that finds a present entry installs it in the cache, so a later cache-only probe of that page returns status 1 without a walk.
- R8: A walk that finds a non-present entry installs nothing, so a later cache-only probe of that page returns status 0.
- R9: Any page may occupy any entry: up to ENTRIES arbitrary pages are cached at once, and all of them hit.
- R10: A fill takes the lowest-numbered invalid entry. When every entry is valid, fills replace entries in round-robin order starting at entry 0.
- R11: A one-cycle `flush` pulse invalidates every cached page, so subsequent cache-only probes return status 0.
- R12: After reset `req_ready`=1 and `rsp_valid`=0. A request is taken when `req_valid` and `req_ready` are both high, and `req_ready` stays low until the response is acknowledged. The response is held stable while `rsp_ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, can take a request |
| req_kind | input | 2 | 0 cache-only probe, 1 walking probe, 2 try-load, 3 as 0 |
| req_nowalk | input | 1 | Try-load aborts on any cache miss |
| req_vaddr | input | VPN_W+OFF_W | Virtual address {page number, offset} |
| rsp_valid | output | 1 | Response present |
| rsp_ack | input | 1 | Response consumed |
| rsp_status | output | 1 | 1 = mapping found / load done |
| rsp_data | output | DATA_W | Loaded word, else 0 |
| rsp_zf | output | 1 | Loaded word is zero |
| rsp_sf | output | 1 | Top bit of loaded word |
| rsp_pf | output | 1 | Loaded word has even parity |
| pte_rd_en | output | 1 | Page-table read strobe |
| pte_rd_addr | output | VPN_W | Page-table index |
| pte_rd_data | input | PPN_W+1 | Entry, one cycle after strobe: top bit present, rest physical page |
| dat_rd_en | output | 1 | Data read strobe |
| dat_rd_addr | output | PPN_W+OFF_W | Physical address |
| dat_rd_data | input | DATA_W | Data word, one cycle after strobe |

## Verification
On every cycle, the assertions check four things. First, that no page-table read is issued for a request kind or mode that forbids walking. Second, that each data read carries the request's original offset. Third, that aborted responses carry a zero result and clear flags, and that the flags of a successful load agree with the returned word. Fourth, that the handshake holds the response stable until it is acknowledged.

Some behaviours only show up across a sequence of requests, so only the bench's scenarios reveal them. These are that fills make later probes hit, that non-present walks leave the cache untouched, the order in which a full cache gives up its entries, and the effect of a flush.

// File: rtl/xlat_probe_pkg.sv
package xlat_probe_pkg;

    typedef enum logic [1:0] {
        KIND_CACHE = 2'd0,
        KIND_WALK  = 2'd1,
        KIND_LOAD  = 2'd2,
        KIND_ALT   = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOK,
        S_PWAIT,
        S_DREAD,
        S_RESP
    } unit_state_e;

    typedef struct packed {
        logic status;
        logic zf;
        logic sf;
        logic pf;
    } rsp_flags_t;

    // True when the request kind may read the page table on a miss
    function automatic logic walk_allowed(input logic [1:0] kind, input logic nowalk);
        return (kind == KIND_WALK) || ((kind == KIND_LOAD) && !nowalk);
    endfunction

endpackage

// File: rtl/xlat_tlb_cam.sv
module xlat_tlb_cam #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 8,
    parameter int PPN_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] ent_vld;
    logic [VPN_W-1:0]   ent_vpn [ENTRIES];
    logic [PPN_W-1:0]   ent_ppn [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   rr_ptr;
    logic [IDX_W-1:0]   victim;
    logic               all_full;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ent_vld[g] && (ent_vpn[g] == lk_vpn);
    end

    always_comb begin
        lk_hit = 1'b0;
        lk_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_hit = 1'b1;
                lk_ppn = lk_ppn | ent_ppn[i];
            end
        end
    end

    assign all_full = &ent_vld;

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = rr_ptr;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && !ent_vld[i]) begin
                victim = IDX_W'(i);
                found  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ent_vld <= '0;
            rr_ptr  <= '0;
        end else if (fill_en) begin
            ent_vld[victim] <= 1'b1;
            ent_vpn[victim] <= fill_vpn;
            ent_ppn[victim] <= fill_ppn;
            if (all_full) begin
                rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/xlat_load_flags.sv
module xlat_load_flags #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] word,
    output logic              zf,
    output logic              sf,
    output logic              pf
);
    assign zf = (word == '0);
    assign sf = word[DATA_W-1];
    assign pf = ~(^word);
endmodule

// File: rtl/xlat_probe_unit.sv
module xlat_probe_unit
    import xlat_probe_pkg::*;
#(
    parameter int VPN_W   = 8,
    parameter int PPN_W   = 8,
    parameter int OFF_W   = 4,
    parameter int ENTRIES = 4,
    parameter int DATA_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [1:0]             req_kind,
    input  logic                   req_nowalk,
    input  logic [VPN_W+OFF_W-1:0] req_vaddr,
    output logic                   rsp_valid,
    input  logic                   rsp_ack,
    output logic                   rsp_status,
    output logic [DATA_W-1:0]      rsp_data,
    output logic                   rsp_zf,
    output logic                   rsp_sf,
    output logic                   rsp_pf,
    output logic                   pte_rd_en,
    output logic [VPN_W-1:0]       pte_rd_addr,
    input  logic [PPN_W:0]         pte_rd_data,
    output logic                   dat_rd_en,
    output logic [PPN_W+OFF_W-1:0] dat_rd_addr,
    input  logic [DATA_W-1:0]      dat_rd_data
);
    localparam int VA_W = VPN_W + OFF_W;

    unit_state_e       st;
    logic [1:0]        cur_kind;
    logic              cur_nowalk;
    logic [VPN_W-1:0]  cur_vpn;
    logic [OFF_W-1:0]  cur_off;
    rsp_flags_t        r_flags;
    logic [DATA_W-1:0] r_data;

    logic              hit;
    logic [PPN_W-1:0]  hit_ppn;
    logic              pte_present;
    logic [PPN_W-1:0]  pte_ppn;
    logic              fill_en;
    logic              is_load;
    logic              may_walk;
    logic              lf_zf, lf_sf, lf_pf;

    assign is_load     = (cur_kind == KIND_LOAD);
    assign may_walk    = walk_allowed(cur_kind, cur_nowalk);
    assign pte_present = pte_rd_data[PPN_W];
    assign pte_ppn     = pte_rd_data[PPN_W-1:0];
    assign fill_en     = (st == S_PWAIT) && pte_present;

    xlat_tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .lk_vpn   (cur_vpn),
        .lk_hit   (hit),
        .lk_ppn   (hit_ppn),
        .fill_en  (fill_en),
        .fill_vpn (cur_vpn),
        .fill_ppn (pte_ppn)
    );

    xlat_load_flags #(.DATA_W(DATA_W)) u_flags (
        .word (dat_rd_data),
        .zf   (lf_zf),
        .sf   (lf_sf),
        .pf   (lf_pf)
    );

    assign req_ready   = (st == S_IDLE);
    assign rsp_valid   = (st == S_RESP);
    assign rsp_status  = r_flags.status;
    assign rsp_zf      = r_flags.zf;
    assign rsp_sf      = r_flags.sf;
    assign rsp_pf      = r_flags.pf;
    assign rsp_data    = r_data;

    assign pte_rd_en   = (st == S_LOOK) && !hit && may_walk;
    assign pte_rd_addr = cur_vpn;
    assign dat_rd_en   = is_load && (((st == S_LOOK) && hit) ||
                                     ((st == S_PWAIT) && pte_present));
    assign dat_rd_addr = {(st == S_LOOK) ? hit_ppn : pte_ppn, cur_off};

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            cur_kind   <= '0;
            cur_nowalk <= 1'b0;
            cur_vpn    <= '0;
            cur_off    <= '0;
            r_flags    <= '0;
            r_data     <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        cur_kind   <= req_kind;
                        cur_nowalk <= req_nowalk;
                        cur_vpn    <= req_vaddr[VA_W-1:OFF_W];
                        cur_off    <= req_vaddr[OFF_W-1:0];
                        st         <= S_LOOK;
                    end
                end
                S_LOOK: begin
                    if (hit && is_load) begin
                        st <= S_DREAD;
                    end else if (hit) begin
                        r_flags <= '{status: 1'b1, default: 1'b0};
                        r_data  <= '0;
                        st      <= S_RESP;
                    end else if (may_walk) begin
                        st <= S_PWAIT;
                    end else begin
                        r_flags <= '0;
                        r_data  <= '0;
                        st      <= S_RESP;
                    end
                end
                S_PWAIT: begin
                    if (pte_present && is_load) begin
                        st <= S_DREAD;
                    end else begin
                        r_flags <= '{status: pte_present, default: 1'b0};
                        r_data  <= '0;
                        st      <= S_RESP;
                    end
                end
                S_DREAD: begin
                    r_flags <= '{status: 1'b1, zf: lf_zf, sf: lf_sf, pf: lf_pf};
                    r_data  <= dat_rd_data;
                    st      <= S_RESP;
                end
                S_RESP: begin
                    if (rsp_ack) st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xlat_probe_chk.sv
module xlat_probe_chk
    import xlat_probe_pkg::*;
#(
    parameter int VPN_W  = 8,
    parameter int PPN_W  = 8,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic [1:0]             req_kind,
    input logic                   req_nowalk,
    input logic [VPN_W+OFF_W-1:0] req_vaddr,
    input logic                   rsp_valid,
    input logic                   rsp_ack,
    input logic                   rsp_status,
    input logic [DATA_W-1:0]      rsp_data,
    input logic                   rsp_zf,
    input logic                   rsp_sf,
    input logic                   rsp_pf,
    input logic                   pte_rd_en,
    input logic                   dat_rd_en,
    input logic [PPN_W+OFF_W-1:0] dat_rd_addr
);
    logic [1:0]       sh_kind;
    logic             sh_nowalk;
    logic [OFF_W-1:0] sh_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_kind   <= '0;
            sh_nowalk <= 1'b0;
            sh_off    <= '0;
        end else if (req_valid && req_ready) begin
            sh_kind   <= req_kind;
            sh_nowalk <= req_nowalk;
            sh_off    <= req_vaddr[OFF_W-1:0];
        end
    end

    // R1, R6: no page-table read unless the kind and mode allow one
    a_r1_no_forbidden_walk: assert property (@(posedge clk) disable iff (rst)
        pte_rd_en |-> ((sh_kind == KIND_WALK) || (sh_kind == KIND_LOAD && !sh_nowalk)));

    // R3: data reads only for try-loads, with the original offset
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
        dat_rd_en |-> (sh_kind == KIND_LOAD) && (dat_rd_addr[OFF_W-1:0] == sh_off));

    // R4: aborts return zero
    a_r4_abort_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_status) |-> (rsp_data == '0) && !rsp_zf && !rsp_sf && !rsp_pf);

    // R5: flags agree with the word for loads, clear otherwise
    a_r5_load_flags: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status && sh_kind == KIND_LOAD) |->
            (rsp_zf == (rsp_data == '0)) && (rsp_sf == rsp_data[DATA_W-1]));

    a_r5_probe_flags: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && sh_kind != KIND_LOAD) |-> !rsp_zf && !rsp_sf && !rsp_pf && (rsp_data == '0));

    // R12: busy while a response is pending, held until acknowledged
    a_r12_busy: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ack) |=> rsp_valid && $stable(rsp_data) && $stable(rsp_status));

endmodule

bind xlat_probe_unit xlat_probe_chk #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_nowalk(req_nowalk), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_status(rsp_status),
    .rsp_data(rsp_data), .rsp_zf(rsp_zf), .rsp_sf(rsp_sf), .rsp_pf(rsp_pf),
    .pte_rd_en(pte_rd_en), .dat_rd_en(dat_rd_en), .dat_rd_addr(dat_rd_addr)
);

// File: tb/test_xlat_probe_unit.sv
`timescale 1ns/1ps
module test_xlat_probe_unit;
    localparam int VPN_W = 8, PPN_W = 8, OFF_W = 4, ENTRIES = 4, DATA_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_kind = '0;
    logic req_nowalk = 1'b0;
    logic [11:0] req_vaddr = '0;
    logic rsp_valid;
    logic rsp_ack = 1'b0;
    logic rsp_status;
    logic [15:0] rsp_data;
    logic rsp_zf, rsp_sf, rsp_pf;
    logic pte_rd_en;
    logic [7:0] pte_rd_addr;
    logic [8:0] pte_rd_data = '0;
    logic dat_rd_en;
    logic [11:0] dat_rd_addr;
    logic [15:0] dat_rd_data = '0;

    int checks = 0;
    int errors = 0;
    int walks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    xlat_probe_unit #(.VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W),
                      .ENTRIES(ENTRIES), .DATA_W(DATA_W)) i_xlat_probe_unit (
        .clk(clk), .rst(rst), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_nowalk(req_nowalk), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_status(rsp_status),
        .rsp_data(rsp_data), .rsp_zf(rsp_zf), .rsp_sf(rsp_sf), .rsp_pf(rsp_pf),
        .pte_rd_en(pte_rd_en), .pte_rd_addr(pte_rd_addr), .pte_rd_data(pte_rd_data),
        .dat_rd_en(dat_rd_en), .dat_rd_addr(dat_rd_addr), .dat_rd_data(dat_rd_data)
    );

    // Memory model: page present unless low two page bits are both 1
    function automatic logic [8:0] pte_of(input logic [7:0] vpn);
        return {vpn[1:0] != 2'b11, vpn ^ 8'h3C};
    endfunction

    function automatic logic [15:0] mdat(input logic [11:0] a);
        if (a[3:0] == 4'hF) return 16'h0000;
        return {a, 4'b0} ^ {4'b0, a} ^ 16'hC3A5;
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (pte_rd_en) begin
            pte_rd_data <= pte_of(pte_rd_addr);
            walks <= walks + 1;
        end
        if (dat_rd_en) dat_rd_data <= mdat(dat_rd_addr);
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        while (cycles < 50000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d cycles expected=<50000", cycles);
        summary();
        $finish;
    end

    task automatic chk(input logic ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    logic       o_st;
    logic [15:0] o_data;
    logic [2:0] o_flags;
    int         o_walks;

    task automatic do_req(input logic [1:0] kind, input logic nw, input logic [11:0] va,
                          input int hold);
        int w0;
        int t;
        @(negedge clk);
        w0 = walks;
        req_kind = kind; req_nowalk = nw; req_vaddr = va; req_valid = 1'b1;
        t = 0;
        while (!req_ready && t < 100) begin @(negedge clk); t++; end
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!rsp_valid && t < 100) begin @(negedge clk); t++; end
        o_st = rsp_status; o_data = rsp_data; o_flags = {rsp_zf, rsp_sf, rsp_pf};
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_data == o_data && rsp_status == o_st, 12,
                "held response", {rsp_valid, rsp_status, rsp_data}, {1'b1, o_st, o_data});
            chk(!req_ready, 12, "ready low while pending", req_ready, 0);
        end
        rsp_ack = 1'b1;
        @(negedge clk);
        rsp_ack = 1'b0;
        o_walks = walks - w0;
    endtask

    typedef struct packed {
        logic [1:0]  kind;
        logic        nw;
        logic [11:0] va;
        logic        st;
        logic        walk;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 12'h013, 1'b0, 1'b0, 4'd1},   // R1 miss, no walk
        '{2'd1, 1'b0, 12'h013, 1'b1, 1'b1, 4'd2},   // R2 walk finds entry
        '{2'd0, 1'b0, 12'h01A, 1'b1, 1'b0, 4'd7},   // R7 fill hits
        '{2'd1, 1'b0, 12'h030, 1'b0, 1'b1, 4'd2},   // R2 non-present
        '{2'd0, 1'b0, 12'h030, 1'b0, 1'b0, 4'd8},   // R8 nothing installed
        '{2'd2, 1'b1, 12'h025, 1'b0, 1'b0, 4'd6},   // R6 nowalk abort
        '{2'd2, 1'b0, 12'h025, 1'b1, 1'b1, 4'd3},   // R3 load via walk
        '{2'd2, 1'b1, 12'h029, 1'b1, 1'b0, 4'd6},   // R6 nowalk but hit
        '{2'd2, 1'b0, 12'h07C, 1'b0, 1'b1, 4'd4},   // R4 load no mapping
        '{2'd1, 1'b0, 12'h040, 1'b1, 1'b1, 4'd9},   // R9
        '{2'd1, 1'b0, 12'h051, 1'b1, 1'b1, 4'd9},   // R9 cache full
        '{2'd1, 1'b0, 12'h012, 1'b1, 1'b0, 4'd9},   // R9 first page still hits
        '{2'd2, 1'b0, 12'h08F, 1'b1, 1'b1, 4'd5},   // R5 zero word, replaces entry 0
        '{2'd0, 1'b0, 12'h010, 1'b0, 1'b0, 4'd10},  // R10 entry 0 gone
        '{2'd0, 1'b0, 12'h020, 1'b1, 1'b0, 4'd10},  // R10 entry 1 kept
        '{2'd1, 1'b0, 12'h090, 1'b1, 1'b1, 4'd10},  // R10 replaces entry 1
        '{2'd0, 1'b0, 12'h020, 1'b0, 1'b0, 4'd10},
        '{2'd0, 1'b0, 12'h040, 1'b1, 1'b0, 4'd10},
        '{2'd0, 1'b0, 12'h050, 1'b1, 1'b0, 4'd10},
        '{2'd0, 1'b0, 12'h080, 1'b1, 1'b0, 4'd10},
        '{2'd0, 1'b0, 12'h090, 1'b1, 1'b0, 4'd10},
        '{2'd3, 1'b0, 12'h0B0, 1'b0, 1'b0, 4'd1},   // R1 kind 3 never walks
        '{2'd2, 1'b1, 12'h046, 1'b1, 1'b0, 4'd5},   // R5 flags on a hit load
        '{2'd1, 1'b1, 12'h0A1, 1'b1, 1'b1, 4'd6}    // R6 probe ignores nowalk
    };

    initial begin
        logic [15:0] ed;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, 12, "ready after reset", req_ready, 1);   // R12
        chk(rsp_valid == 1'b0, 12, "no response after reset", rsp_valid, 0);

        for (int v = 0; v < NV; v++) begin
            do_req(VECS[v].kind, VECS[v].nw, VECS[v].va, 0);
            chk(o_st == VECS[v].st, int'(VECS[v].rq), $sformatf("vec %0d status", v),
                o_st, VECS[v].st);
            chk((o_walks != 0) == VECS[v].walk, int'(VECS[v].rq), $sformatf("vec %0d walk", v),
                o_walks, VECS[v].walk);
            if (VECS[v].kind == 2'd2 && VECS[v].st) begin
                ed = mdat({VECS[v].va[11:4] ^ 8'h3C, VECS[v].va[3:0]});
                chk(o_data == ed, 3, $sformatf("vec %0d data", v), o_data, ed);
                chk(o_flags == {ed == 16'h0, ed[15], ~(^ed)}, 5,
                    $sformatf("vec %0d flags", v), o_flags, {ed == 16'h0, ed[15], ~(^ed)});
            end else begin
                chk(o_data == 16'h0, 4, $sformatf("vec %0d zero result", v), o_data, 0);
                chk(o_flags == 3'b000, 5, $sformatf("vec %0d flags clear", v), o_flags, 0);
            end
        end

        // R11: flush empties the cache
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        do_req(2'd0, 1'b0, 12'h090, 0);
        chk(o_st == 1'b0, 11, "page gone after flush", o_st, 0);
        do_req(2'd0, 1'b0, 12'h0A0, 0);
        chk(o_st == 1'b0, 11, "second page gone after flush", o_st, 0);

        // R12: response held while ack stays low
        do_req(2'd2, 1'b0, 12'h042, 4);
        ed = mdat({8'h04 ^ 8'h3C, 4'h2});
        chk(o_st == 1'b1 && o_data == ed, 12, "held load result", o_data, ed);

        summary();
        $finish;
    end
endmodule